// File: doc/BRIEF.md
# Bus Address Translation Map

This block turns a peripheral bus address into a system physical address. It holds a file of 512 map entries, one per 512-byte page of the peripheral bus. Software loads and reads the entries through a simple register port. A transfer engine presents a bus address on the request port. One cycle later the block returns the physical address and a status code: ok, ignore, invalid-map or non-existent-target.

Each entry carries the following:
- a page frame number;
- a valid bit;
- a flag that permits an I/O-space target;
- an odd-byte flag, which moves the target up by one byte when a data path is named;
- a data-path number;
- a longword-access flag, which together with data path 6 or 7 drops the transfer silently.

An entry whose stored bits are all set is a sentinel that drops the transfer without complaint. Two kinds of failed translation raise a one-cycle error pulse toward a separate status block:
- a valid entry whose target lies outside both the memory range and the permitted I/O range, which also reports the failing address;
- an entry with the valid bit clear.

A debug port translates combinationally and never raises an error.

Top module: `bus_xlate_map`

## Requirements
- R1: After reset, entries 0 to USABLE-1 (495 by default) read 0x00000000. Entries USABLE to 511 read 0xC6FFFFFF, which is every storable bit set.
- R2: An entry keeps only bits 31 (valid), 30 (I/O allowed), 26 (longword access), 25 (odd byte), 23:21 (data path) and 20:0 (page frame). A register read returns the stored value with every other bit zero.
- R3: A strobe on `xl_req` produces `xl_done` high for exactly one cycle, in the following cycle. `xl_status`, `xl_paddr` and the error pulses are valid only in that cycle. Status codes are 0 = ok, 1 = ignore, 2 = invalid-map and 3 = non-existent-target.
- R4: A valid entry with a target in memory (below MEM_LIMIT) gives status 0. The physical address is the page frame shifted left by 9, ORed with address bits 8:0. The map index is address bits above bit 8.
- R5: A sentinel entry (reads 0xC6FFFFFF) gives status 1 and raises no error.
- R6: When the data-path field is nonzero and the odd-byte flag is set, the physical address is one higher. With data path 0, the odd-byte flag has no effect.
- R7: Odd byte, longword access and data path 6 or 7 together give status 1 with no error. Data path 5 with the same flags only adds one.
- R8: A target in [IO_BASE, IO_LIMIT) succeeds only when the I/O flag is set. A target that lies in neither range, or in the I/O range without the flag, gives status 3, pulses `err_nxm` and presents the physical address on `err_addr`.
- R9: An entry with the valid bit clear gives status 2 and pulses `err_inv_map`.
- R10: A map index of NUM_ENTRIES or above gives status 2, reads no entry and raises no error.
- R11: The debug port gives `dbg_paddr` combinationally, with the odd-byte adjustment applied. `dbg_ok` is the valid bit of an in-range entry. The debug port never drives the error outputs.
- R12: A map write and a translation strobe to the same page in the same cycle give a translation that uses the newly written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write enable for a map entry |
| reg_idx | input | IDX_W (9) | Map entry index for the register port |
| reg_wdata | input | 32 | Entry write data |
| reg_rdata | output | 32 | Stored entry at `reg_idx` |
| xl_req | input | 1 | Translation strobe |
| xl_addr | input | BUS_AW (18) | Peripheral bus address to translate |
| xl_done | output | 1 | Result valid |
| xl_status | output | 2 | Result code |
| xl_paddr | output | 30 | Translated physical address |
| err_inv_map | output | 1 | Invalid-map error pulse |
| err_nxm | output | 1 | Non-existent-target error pulse |
| err_addr | output | 30 | Failing physical address, meaningful with `err_nxm` |
| dbg_addr | input | BUS_AW (18) | Debug translation address |
| dbg_ok | output | 1 | Debug translation found a valid entry |
| dbg_paddr | output | 30 | Debug translated address |

## Verification
A map write and a translation strobe can fall in the same cycle. When they target the same page, the result must reflect the entry being written, not the old contents. The bench checks this with a page that still holds its reset value of zero, which would give invalid-map. It raises `reg_we` and `xl_req` on the same edge and expects status ok, no error pulse, and an address built from the new page frame. The debug port also works while translations run, and the bench confirms that the debug port leaves the error pulses quiet.

// File: rtl/bus_xlate_map.sv
module bus_xlate_map #(
  parameter int BUS_AW      = 18,
  parameter int NUM_ENTRIES = 512,
  parameter int USABLE      = 496,
  parameter int PAGE_BITS   = 9,
  parameter longint MEM_LIMIT = 'h0100_0000,
  parameter longint IO_BASE   = 'h2000_0000,
  parameter longint IO_LIMIT  = 'h3000_0000,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int PA_W  = 21 + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xl_req,
  input  logic [BUS_AW-1:0] xl_addr,
  output logic              xl_done,
  output logic [1:0]        xl_status,
  output logic [PA_W-1:0]   xl_paddr,
  output logic              err_inv_map,
  output logic              err_nxm,
  output logic [PA_W-1:0]   err_addr,
  input  logic [BUS_AW-1:0] dbg_addr,
  output logic              dbg_ok,
  output logic [PA_W-1:0]   dbg_paddr
);
  localparam int XI_W = BUS_AW - PAGE_BITS;
  localparam logic [31:0] KEEP = 32'hC6FF_FFFF;
  localparam logic [PA_W-1:0] MEM_TOP = PA_W'(MEM_LIMIT);
  localparam logic [PA_W-1:0] IO_LO   = PA_W'(IO_BASE);
  localparam logic [PA_W-1:0] IO_HI   = PA_W'(IO_LIMIT);
  localparam logic [1:0] ST_OK = 2'd0, ST_IGN = 2'd1, ST_INV = 2'd2, ST_NXM = 2'd3;

  logic [31:0] map_q [NUM_ENTRIES];
  logic              req_q;
  logic [BUS_AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        map_q[i] <= (i < USABLE) ? 32'h0 : KEEP;
    end else if (reg_we) begin
      map_q[reg_idx] <= reg_wdata & KEEP;
    end
  end

  assign reg_rdata = map_q[reg_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= xl_req;
      if (xl_req) addr_q <= xl_addr;
    end
  end

  // request-side lookup
  logic [XI_W-1:0] xidx;
  logic [31:0]     ent;
  logic            in_rng, bump, drop;
  logic [PA_W-1:0] pa;
  logic [1:0]      st;
  logic            inv, nxm;

  assign xidx   = addr_q[BUS_AW-1:PAGE_BITS];
  assign in_rng = 32'(xidx) < 32'(NUM_ENTRIES);
  assign ent    = map_q[xidx[IDX_W-1:0]];
  assign bump   = (ent[23:21] != 3'd0) && ent[25];
  assign drop   = bump && ent[26] && (ent[23:21] >= 3'd6);
  assign pa     = {ent[20:0], addr_q[PAGE_BITS-1:0]} + PA_W'(bump);

  always_comb begin
    st  = ST_OK;
    inv = 1'b0;
    nxm = 1'b0;
    if (!in_rng)                                     st = ST_INV;
    else if (ent == KEEP)                            st = ST_IGN;
    else if (!ent[31]) begin                         st = ST_INV; inv = 1'b1; end
    else if (drop)                                   st = ST_IGN;
    else if ((pa < MEM_TOP) ||
             (ent[30] && pa >= IO_LO && pa < IO_HI)) st = ST_OK;
    else begin                                       st = ST_NXM; nxm = 1'b1; end
  end

  assign xl_done     = req_q;
  assign xl_status   = req_q ? st : ST_OK;
  assign xl_paddr    = pa;
  assign err_inv_map = req_q & inv;
  assign err_nxm     = req_q & nxm;
  assign err_addr    = pa;

  // debug lookup, no side effects
  logic [XI_W-1:0] didx;
  logic [31:0]     dent;
  logic            dbump;

  assign didx      = dbg_addr[BUS_AW-1:PAGE_BITS];
  assign dent      = map_q[didx[IDX_W-1:0]];
  assign dbump     = (dent[23:21] != 3'd0) && dent[25];
  assign dbg_ok    = (32'(didx) < 32'(NUM_ENTRIES)) && dent[31];
  assign dbg_paddr = {dent[20:0], dbg_addr[PAGE_BITS-1:0]} + PA_W'(dbump);

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_done); // R3
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !xl_done); // R3
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_inv_map, err_nxm})); // R8
  AST_NXM_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    err_nxm |-> (xl_done && xl_status == ST_NXM && err_addr == xl_paddr)); // R8
  AST_INV_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    err_inv_map |-> (xl_done && xl_status == ST_INV)); // R9
  AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $stable(reg_idx))
      |-> reg_rdata == ($past(reg_wdata) & KEEP)); // R2
endmodule

// File: tb/bus_xlate_map_test.sv
module bus_xlate_map_test;
  localparam int PA_W = 30;
  localparam logic [1:0] OK = 2'd0, IGN = 2'd1, INV = 2'd2, NXM = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              reg_we = 1'b0;
  logic [8:0]        reg_idx = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              xl_req = 1'b0;
  logic [17:0]       xl_addr = '0;
  logic              xl_done;
  logic [1:0]        xl_status;
  logic [PA_W-1:0]   xl_paddr, err_addr, dbg_paddr;
  logic              err_inv_map, err_nxm, dbg_ok;
  logic [17:0]       dbg_addr = '0;

  bus_xlate_map uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_req(xl_req),
    .xl_addr(xl_addr), .xl_done(xl_done), .xl_status(xl_status),
    .xl_paddr(xl_paddr), .err_inv_map(err_inv_map), .err_nxm(err_nxm),
    .err_addr(err_addr), .dbg_addr(dbg_addr), .dbg_ok(dbg_ok),
    .dbg_paddr(dbg_paddr));

  // wider bus so indices beyond the map can be presented (R10)
  logic              w_req = 1'b0;
  logic [18:0]       w_addr = '0;
  logic              w_done, w_inv, w_nxm, w_dok;
  logic [1:0]        w_status;
  logic [31:0]       w_rdata;
  logic [PA_W-1:0]   w_paddr, w_eaddr, w_dpaddr;

  bus_xlate_map #(.BUS_AW(19)) uut_wide (
    .clk(clk), .rst_n(rst_n), .reg_we(1'b0), .reg_idx(9'd0),
    .reg_wdata(32'd0), .reg_rdata(w_rdata), .xl_req(w_req),
    .xl_addr(w_addr), .xl_done(w_done), .xl_status(w_status),
    .xl_paddr(w_paddr), .err_inv_map(w_inv), .err_nxm(w_nxm),
    .err_addr(w_eaddr), .dbg_addr(19'd0), .dbg_ok(w_dok),
    .dbg_paddr(w_dpaddr));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_map(input int idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 9'(idx); reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_map(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_idx = 9'(idx);
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic xlate(input logic [17:0] a, input logic [1:0] es, input logic [PA_W-1:0] ep,
                       input bit einv, input bit enxm, input string tag);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
    check(xl_done == 1'b1, {tag, " done"}, xl_done, 1);
    check(xl_status == es, {tag, " status"}, xl_status, es);
    if (es == OK || es == NXM) check(xl_paddr == ep, {tag, " paddr"}, xl_paddr, ep);
    check(err_inv_map == einv, {tag, " inv flag"}, err_inv_map, einv);
    check(err_nxm == enxm, {tag, " nxm flag"}, err_nxm, enxm);
    if (enxm) check(err_addr == ep, {tag, " err_addr"}, err_addr, ep);
    @(negedge clk);
    check(xl_done == 1'b0, {tag, " done drops R3"}, xl_done, 0);
  endtask

  task automatic t_reset;
    check(xl_done == 1'b0, "R3 idle after reset", xl_done, 0);
    read_map(0,   32'h0, "R1 entry 0");
    read_map(100, 32'h0, "R1 entry 100");
    read_map(495, 32'h0, "R1 entry 495");
    read_map(496, 32'hC6FF_FFFF, "R1 entry 496");
    read_map(511, 32'hC6FF_FFFF, "R1 entry 511");
  endtask

  task automatic t_mask;
    write_map(5, 32'hFFFF_FFFF);
    read_map(5, 32'hC6FF_FFFF, "R2 all ones masked");
    write_map(5, 32'h3900_0000);
    read_map(5, 32'h0, "R2 unstored bits dropped");
    write_map(5, 32'h8123_4567);
    read_map(5, 32'h8023_4567, "R2 mixed pattern");
  endtask

  task automatic t_basic;
    write_map(1, 32'h8000_0123);
    xlate(18'h0245, OK, 30'h0002_4645, 0, 0, "R4 basic");
    write_map(2, 32'h8000_07FF);
    xlate(18'h05FF, OK, 30'h000F_FFFF, 0, 0, "R4 top offset");
  endtask

  task automatic t_sentinel;
    xlate(18'(496 << 9), IGN, '0, 0, 0, "R5 sentinel 496");
    xlate(18'((511 << 9) | 3), IGN, '0, 0, 0, "R5 sentinel 511");
  endtask

  task automatic t_odd;
    write_map(3, 32'h8240_0010);
    xlate(18'h0604, OK, 30'h0000_2005, 0, 0, "R6 odd with path");
    write_map(4, 32'h8200_0010);
    xlate(18'h0804, OK, 30'h0000_2004, 0, 0, "R6 odd path zero");
  endtask

  task automatic t_drop;
    write_map(6, 32'h86C0_0010);
    xlate(18'h0C04, IGN, '0, 0, 0, "R7 path 6 dropped");
    write_map(6, 32'h86E0_0010);
    xlate(18'h0C04, IGN, '0, 0, 0, "R7 path 7 dropped");
    write_map(6, 32'h86A0_0010);
    xlate(18'h0C04, OK, 30'h0000_2005, 0, 0, "R7 path 5 bumps");
    write_map(6, 32'h84C0_0010);
    xlate(18'h0C04, OK, 30'h0000_2004, 0, 0, "R7 no odd no drop");
  endtask

  task automatic t_io;
    write_map(7, 32'hC010_0000);
    xlate(18'h0E10, OK, 30'h2000_0010, 0, 0, "R8 io permitted");
    write_map(8, 32'h8010_0000);
    xlate(18'h1010, NXM, 30'h2000_0010, 0, 1, "R8 io not permitted");
    write_map(9, 32'hC00C_0000);
    xlate(18'h1220, NXM, 30'h1800_0020, 0, 1, "R8 outside both ranges");
  endtask

  task automatic t_invalid;
    xlate(18'h1404, INV, '0, 1, 0, "R9 invalid entry");
  endtask

  task automatic t_range;
    @(negedge clk);
    w_req = 1'b1; w_addr = 19'((600 << 9) | 7);
    @(negedge clk);
    w_req = 1'b0;
    check(w_done == 1'b1, "R10 done", w_done, 1);
    check(w_status == INV, "R10 out of range status", w_status, INV);
    check(w_inv == 1'b0 && w_nxm == 1'b0, "R10 no flag", {w_inv, w_nxm}, 0);
    @(negedge clk);
    w_req = 1'b1; w_addr = 19'(88 << 9);
    @(negedge clk);
    w_req = 1'b0;
    check(w_inv == 1'b1, "R10 contrast in-range invalid flags", w_inv, 1);
  endtask

  task automatic t_debug;
    @(negedge clk);
    dbg_addr = 18'h0604;
    #1;
    check(dbg_ok == 1'b1, "R11 dbg ok", dbg_ok, 1);
    check(dbg_paddr == 30'h0000_2005, "R11 dbg odd adjust", dbg_paddr, 30'h2005);
    dbg_addr = 18'h1404;
    #1;
    check(dbg_ok == 1'b0, "R11 dbg invalid", dbg_ok, 0);
    dbg_addr = 18'h1010;
    #1;
    check(dbg_ok == 1'b1 && dbg_paddr == 30'h2000_0010, "R11 dbg ignores range", dbg_paddr, 30'h2000_0010);
    @(negedge clk);
    check(err_inv_map == 1'b0 && err_nxm == 1'b0, "R11 dbg raises no flag", {err_inv_map, err_nxm}, 0);
  endtask

  task automatic t_same_cycle;
    read_map(11, 32'h0, "R12 entry starts empty");
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 9'd11; reg_wdata = 32'h8000_0055;
    xl_req = 1'b1; xl_addr = 18'h1602;
    @(negedge clk);
    reg_we = 1'b0; xl_req = 1'b0;
    check(xl_status == OK, "R12 status sees new entry", xl_status, OK);
    check(xl_paddr == 30'h0000_AA02, "R12 paddr from new entry", xl_paddr, 30'hAA02);
    check(err_inv_map == 1'b0, "R12 no stale invalid flag", err_inv_map, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_basic();
    t_sentinel();
    t_odd();
    t_drop();
    t_io();
    t_invalid();
    t_range();
    t_debug();
    t_same_cycle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule